// File: doc/BRIEF.md
# Thermal Limit Alert with Fault Queue

This block watches a stream of finished temperature samples and decides when an over- or under-temperature alert should be raised. Each sample is a 12-bit left-justified two's-complement value. It arrives with a one-cycle valid strobe and is compared, as a signed number over all 12 bits, against a high limit and a low limit supplied by the surrounding register file. A fault queue filters noise: the alert changes state only after a chosen number of back-to-back faulting samples. Any non-faulting sample in between restarts the count.

There are two modes. In thermostat (comparator) mode the alert follows the temperature with hysteresis. It turns on at or above the high limit and turns off below the low limit. In latched interrupt mode the alert stays on until software clears it, either by a register read or by winning an alert-response arbitration. After each clear, the block re-arms on the opposite limit. The output pin polarity is selectable. A status bit tells an alert-response responder whether the high or the low limit caused the alert.

The surrounding logic also delivers three restart events to the block: entry into shutdown, a general-call reset and a change of mode. Each of them drops the alert and starts filtering afresh.

Top module: `tlim_alert`

## Requirements
- R1: The fault-queue select `fq_sel` sets the number of consecutive faulting samples needed to change the alert state: code 0 needs 1, code 1 needs 2, code 2 needs 4, code 3 needs 6.
- R2: The faults must be consecutive: a valid sample that is not a fault for the current watch condition resets the count to zero.
- R3: Comparator mode (`intr_mode`=0): an inactive alert becomes active after the required run of samples with sample >= high limit. An active alert becomes inactive after the required run of samples with sample < low limit. Without a sample strobe or restart event the state holds.
- R4: In comparator mode the `reg_rd_clr` and `arb_won_clr` pulses have no effect on the alert.
- R5: Interrupt mode (`intr_mode`=1): the alert becomes active after the required run of faults against the armed limit. It then holds regardless of samples until a `reg_rd_clr` or `arb_won_clr` pulse clears it.
- R6: Interrupt arming starts on the high limit (sample >= high). Each clear flips it: after a clear the alert can next rise only on samples below the low limit, and after that alert is cleared, only on the high limit again.
- R7: `alert_src` is 1 while an alert caused by the high limit is active. It is 0 while an alert caused by the low limit is active, and 0 whenever the alert is inactive.
- R8: `alert_pin` is low when the alert is active and `pol`=0, and high when the alert is active and `pol`=1. It is the inverse level when the alert is inactive.
- R9: A rising edge of `shdn` clears the alert and the fault count, and re-arms interrupt mode on the high limit.
- R10: After reset, and in the cycle after a `gc_reset` pulse, the alert is inactive, `alert_src` is 0, the count is zero and the arming is on the high limit.
- R11: Both comparisons are signed over all 12 bits: a sample equal to the high limit is a high fault, and a sample equal to the low limit is not a low fault.
- R12: A clear pulse takes precedence over a sample strobe in the same cycle, and that sample is discarded. A change of `intr_mode` restarts the block as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One-cycle strobe: a conversion finished |
| sample | input | 12 | Finished temperature sample, two's complement |
| hi_lim | input | 12 | High limit, two's complement |
| lo_lim | input | 12 | Low limit, two's complement |
| fq_sel | input | 2 | Fault-queue depth code |
| intr_mode | input | 1 | 0 comparator mode, 1 latched interrupt mode |
| pol | input | 1 | Alert pin polarity, 1 active high |
| shdn | input | 1 | Shutdown level; its rising edge clears |
| gc_reset | input | 1 | General-call reset pulse |
| reg_rd_clr | input | 1 | Register-read clear pulse |
| arb_won_clr | input | 1 | Won alert-response clear pulse |
| alert_pin | output | 1 | Alert output level |
| alert_src | output | 1 | Alert cause, 1 high limit, 0 low limit |

## Verification
The bench sweeps every queue depth in both polarities and both modes, and counts faults to one short of the depth. A queue that trips early, or that keeps counting across a non-faulting sample, would raise the alert one check too soon. Every 12-bit sample is compared against limits that straddle zero, with the sample equal to each limit included. An unsigned compare would flag negative temperatures as hot, and an off-by-one limit would misplace the equality case. In interrupt mode the bench follows the high-low-high arming cycle and sends samples the wrong way for the current arming. It also fires a clear together with a sample, and toggles shutdown and mode. A design that does not flip the arming, lets a same-cycle sample re-arm, or forgets to re-arm high after shutdown ends up with the wrong pin level or source bit.

// File: rtl/talrt_pkg.sv
package talrt_pkg;
  localparam int unsigned TEMP_W = 12;
  localparam int unsigned QCNT_W = 3;
  localparam int unsigned FQ_W   = 2;

  // depth of the fault queue for each select code
  function automatic logic [QCNT_W-1:0] fq_depth(input logic [FQ_W-1:0] code);
    logic [QCNT_W-1:0] d;
    case (code)
      2'd0:    d = QCNT_W'(1);
      2'd1:    d = QCNT_W'(2);
      2'd2:    d = QCNT_W'(4);
      default: d = QCNT_W'(6);
    endcase
    return d;
  endfunction
endpackage

// File: rtl/talrt_cmp.sv
module talrt_cmp #(
  parameter int unsigned TW = talrt_pkg::TEMP_W
) (
  input  logic [TW-1:0] smp,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  output logic          at_or_above_hi,
  output logic          below_lo
);
  always_comb begin
    at_or_above_hi = $signed(smp) >= $signed(hi_lim);
    below_lo       = $signed(smp) <  $signed(lo_lim);
  end
endmodule

// File: rtl/talrt_fault_q.sv
module talrt_fault_q #(
  parameter int unsigned QW = talrt_pkg::QCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          fault,
  input  logic [QW-1:0] need,
  input  logic          flush,
  input  logic          hold,
  output logic          trip,
  output logic [QW-1:0] cnt
);
  logic [QW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          cnt_en;

  always_comb begin
    cnt_inc = cnt_q + QW'(1);
    trip    = smp_vld & fault & ~flush & ~hold & (cnt_inc >= need);
    cnt_en  = flush | hold | smp_vld;
    if (flush || hold)          cnt_d = '0;
    else if (fault && !trip)    cnt_d = cnt_inc;
    else                        cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/talrt_state.sv
module talrt_state (
  input  logic clk,
  input  logic rst_n,
  input  logic intr_mode,
  input  logic shdn,
  input  logic gc_reset,
  input  logic rd_clr,
  input  logic won_clr,
  input  logic trip,
  output logic active,
  output logic src,
  output logic watch_hi,
  output logic hold,
  output logic flush
);
  logic act_q, act_d;
  logic arm_hi_q, arm_hi_d;
  logic src_q, src_d;
  logic shdn_q, mode_q;
  logic shdn_rise, mode_chg, restart, clr_take;

  always_comb begin
    shdn_rise = shdn & ~shdn_q;
    mode_chg  = intr_mode ^ mode_q;
    restart   = gc_reset | shdn_rise | mode_chg;
    clr_take  = intr_mode & act_q & (rd_clr | won_clr);
    flush     = restart | clr_take;
    hold      = intr_mode & act_q;
    watch_hi  = intr_mode ? arm_hi_q : ~act_q;

    act_d    = act_q;
    arm_hi_d = arm_hi_q;
    src_d    = src_q;
    if (restart) begin
      act_d    = 1'b0;
      arm_hi_d = 1'b1;
      src_d    = 1'b0;
    end else if (clr_take) begin
      act_d    = 1'b0;
      arm_hi_d = ~arm_hi_q;
      src_d    = 1'b0;
    end else if (trip) begin
      if (intr_mode) begin
        act_d = 1'b1;
        src_d = arm_hi_q;
      end else begin
        act_d = ~act_q;
        src_d = ~act_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      arm_hi_q <= 1'b1;
      src_q    <= 1'b0;
      shdn_q   <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      act_q    <= act_d;
      arm_hi_q <= arm_hi_d;
      src_q    <= src_d;
      shdn_q   <= shdn;
      mode_q   <= intr_mode;
    end
  end

  assign active = act_q;
  assign src    = src_q;
endmodule

// File: rtl/tlim_alert.sv
module tlim_alert #(
  parameter int unsigned TW = talrt_pkg::TEMP_W,
  parameter int unsigned QW = talrt_pkg::QCNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_vld,
  input  logic [TW-1:0] sample,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  input  logic [1:0]    fq_sel,
  input  logic          intr_mode,
  input  logic          pol,
  input  logic          shdn,
  input  logic          gc_reset,
  input  logic          reg_rd_clr,
  input  logic          arb_won_clr,
  output logic          alert_pin,
  output logic          alert_src
);
  logic          at_hi, below_lo, fault;
  logic          watch_hi, hold, flush, trip, active;
  logic [QW-1:0] need, fault_cnt;

  assign need = talrt_pkg::fq_depth(fq_sel);

  talrt_cmp #(.TW(TW)) i_cmp (
    .smp(sample), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .at_or_above_hi(at_hi), .below_lo(below_lo)
  );

  assign fault = watch_hi ? at_hi : below_lo;

  talrt_fault_q #(.QW(QW)) i_fq (
    .clk(clk), .rst_n(rst_n), .smp_vld(sample_vld), .fault(fault),
    .need(need), .flush(flush), .hold(hold), .trip(trip), .cnt(fault_cnt)
  );

  talrt_state i_st (
    .clk(clk), .rst_n(rst_n), .intr_mode(intr_mode), .shdn(shdn),
    .gc_reset(gc_reset), .rd_clr(reg_rd_clr), .won_clr(arb_won_clr),
    .trip(trip), .active(active), .src(alert_src), .watch_hi(watch_hi),
    .hold(hold), .flush(flush)
  );

  assign alert_pin = pol ? active : ~active;
endmodule

// File: rtl/talrt_chk.sv
module talrt_chk #(
  parameter int unsigned QW = talrt_pkg::QCNT_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_vld,
  input logic          intr_mode,
  input logic          pol,
  input logic          shdn,
  input logic          gc_reset,
  input logic          reg_rd_clr,
  input logic          arb_won_clr,
  input logic          alert_pin,
  input logic          alert_src,
  input logic          active,
  input logic [QW-1:0] fault_cnt
);
  // R1
  fq_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt < QW'(6));

  // R7
  src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pin != pol) |-> !alert_src);

  // R10
  gc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (!active && !alert_src));

  // R9
  shdn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && !$past(shdn)) |=> !active);

  // R5
  intr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_mode && active && !reg_rd_clr && !arb_won_clr && !gc_reset &&
     !(shdn && !$past(shdn)) && intr_mode == $past(intr_mode)) |=> active);

  // R4
  cmp_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!intr_mode && !$past(intr_mode) && (reg_rd_clr || arb_won_clr) &&
     !sample_vld && !gc_reset && !(shdn && !$past(shdn))) |=> $stable(active));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && !reg_rd_clr && !arb_won_clr && !gc_reset &&
     !(shdn && !$past(shdn)) && intr_mode == $past(intr_mode)) |=> $stable(active));

  // R8
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(active) && pol != $past(pol)) |-> alert_pin != $past(alert_pin));
endmodule

bind tlim_alert talrt_chk #(.QW(QW)) i_talrt_chk (
  .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .intr_mode(intr_mode),
  .pol(pol), .shdn(shdn), .gc_reset(gc_reset), .reg_rd_clr(reg_rd_clr),
  .arb_won_clr(arb_won_clr), .alert_pin(alert_pin), .alert_src(alert_src),
  .active(active), .fault_cnt(fault_cnt)
);

// File: tb/test_tlim_alert.sv
module test_tlim_alert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_vld, intr_mode, pol, shdn, gc_reset, reg_rd_clr, arb_won_clr;
  logic [11:0] sample, hi_lim, lo_lim;
  logic [1:0]  fq_sel;
  logic        alert_pin, alert_src;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  localparam logic [11:0] HOT  = 12'h500;  // equals high limit
  localparam logic [11:0] MID  = 12'h4C0;
  localparam logic [11:0] COLD = 12'h4AF;

  always #5 clk = ~clk;

  tlim_alert i_tlim_alert (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .sample(sample),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .fq_sel(fq_sel), .intr_mode(intr_mode),
    .pol(pol), .shdn(shdn), .gc_reset(gc_reset), .reg_rd_clr(reg_rd_clr),
    .arb_won_clr(arb_won_clr), .alert_pin(alert_pin), .alert_src(alert_src)
  );

  task automatic chk(input logic ea, input logic es, input string tag);
    logic ep;
    ep = pol ? ea : !ea;
    checks++;
    if (alert_pin !== ep || alert_src !== es) begin
      errors++;
      $display("FAIL %s: pin=%b src=%b expected pin=%b src=%b", tag, alert_pin, alert_src, ep, es);
    end
  endtask

  task automatic smp(input logic [11:0] s);
    sample = s; sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic gc();
    gc_reset = 1'b1; @(negedge clk); gc_reset = 1'b0;
  endtask

  task automatic rd();
    reg_rd_clr = 1'b1; @(negedge clk); reg_rd_clr = 1'b0;
  endtask

  task automatic won();
    arb_won_clr = 1'b1; @(negedge clk); arb_won_clr = 1'b0;
  endtask

  function automatic int depth(input int c);
    return (c == 3) ? 6 : (1 << c);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_vld = 0; intr_mode = 0; pol = 0; shdn = 0;
    gc_reset = 0; reg_rd_clr = 0; arb_won_clr = 0; sample = '0;
    hi_lim = 12'h500; lo_lim = 12'h4B0; fq_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, 0, "R10 reset state");

    for (int p = 0; p < 2; p++) begin
      pol = p[0];
      for (int c = 0; c < 4; c++) begin
        int n;
        n = depth(c);
        fq_sel = c[1:0];
        // comparator mode
        intr_mode = 0; @(negedge clk); gc();
        repeat (n-1) smp(HOT);
        chk(0, 0, "R1 one short of depth");
        if (n > 1) begin
          smp(MID);
          repeat (n-1) smp(HOT);
          chk(0, 0, "R2 run broken by non-fault");
        end
        smp(HOT);
        chk(1, 1, "R1 R3 R8 R11 trip at high limit");
        rd(); won();
        chk(1, 1, "R4 clears ignored");
        repeat (n-1) smp(COLD);
        smp(12'h4B0);
        repeat (n-1) smp(COLD);
        chk(1, 1, "R2 R11 low limit equality is no fault");
        smp(COLD);
        chk(0, 0, "R3 release below low");
        // interrupt mode
        intr_mode = 1; @(negedge clk);
        repeat (n) smp(HOT);
        chk(1, 1, "R5 R7 interrupt high");
        repeat (3) smp(COLD);
        chk(1, 1, "R5 samples ignored while latched");
        rd();
        chk(0, 0, "R5 read clears");
        repeat (n) smp(HOT);
        chk(0, 0, "R6 armed low ignores hot");
        repeat (n) smp(COLD);
        chk(1, 0, "R6 R7 low-limit alert");
        won();
        chk(0, 0, "R5 won clears");
        repeat (n) smp(COLD);
        chk(0, 0, "R6 armed high ignores cold");
        repeat (n) smp(HOT);
        chk(1, 1, "R6 back to high");
        pol = ~pol; @(negedge clk);
        chk(1, 1, "R8 polarity flip");
        pol = p[0];
        rd();
        shdn = 1; @(negedge clk);
        chk(0, 0, "R9 shutdown entry clears");
        repeat (n) smp(COLD);
        chk(0, 0, "R9 re-armed on high");
        shdn = 0; @(negedge clk);
        repeat (n) smp(HOT);
        chk(1, 1, "R9 high after shutdown");
        intr_mode = 0; @(negedge clk);
        chk(0, 0, "R12 mode change restarts");
      end
    end

    // clear beats same-cycle sample
    pol = 0; fq_sel = 0; intr_mode = 1; @(negedge clk);
    smp(HOT);
    chk(1, 1, "R5 fq0 interrupt");
    reg_rd_clr = 1; sample = COLD; sample_vld = 1;
    @(negedge clk);
    reg_rd_clr = 0; sample_vld = 0;
    chk(0, 0, "R12 clear wins over sample");
    smp(COLD);
    chk(1, 0, "R12 R6 next cold trips");
    gc();
    chk(0, 0, "R10 general-call reset");
    smp(COLD);
    chk(0, 0, "R10 re-armed on high");

    // exhaustive signed sweep, limits straddling zero
    intr_mode = 0; @(negedge clk);
    hi_lim = 12'h050; lo_lim = 12'hFB0;
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] s;
      logic e;
      s = i[11:0];
      gc();
      smp(s);
      e = ($signed(s) >= $signed(hi_lim));
      chk(e, e, "R11 high compare");
      gc();
      smp(12'h050);
      smp(s);
      e = !($signed(s) < $signed(lo_lim));
      chk(e, e, "R11 low compare");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule